// File: doc/BRIEF.md
# Phase-to-Divider Modulation Path

This block turns a stream of polar phase samples into a divider offset for a fractional-N synthesizer, one offset per reference cycle. Each phase sample is differenced against the one before it to give instantaneous frequency. A first-order high-boost filter then lifts the fast part of that frequency, so that modulation survives the narrow closed-loop bandwidth of the synthesizer loop. The filtered frequency is doubled, because the oscillator runs at twice the carrier, and added to a channel word. The sum is clamped into the fractional range and fed to a third-order cascaded noise-shaping modulator.

The modulator's output is a small signed integer that the divider adds to its nominal count N. Every stage advances only on a strobe at the reference rate, so the block can run from a faster system clock. The divider, the loop filter and the oscillator lie outside the block.

Top module: `phdiv_path`

## Requirements
- R1: While `rst` is high on a rising clock edge, all state is cleared, and `div_off` reads 0 from the following cycle.
- R2: On each enabled sample the frequency is `phase_in` minus the previous enabled `phase_in`, taken modulo 2^PHASE_W and read as a signed PHASE_W-bit number, so a phase ramp that passes through zero gives a steady step.
- R3: The first enabled sample after reset produces a frequency of 0, whatever its phase value.
- R4: With `boost_en` high, the filtered value is f[n] + 2^`boost_shift` * (f[n] - f[n-1]). With `boost_en` low, it is f[n] unchanged.
- R5: The modulator input word is `chan_word` plus twice the filtered value, clamped to the range 0 to 2^FRAC_W-1.
- R6: The modulator has three first-order accumulator stages. Stage 1 adds the word, stage 2 adds stage 1's new accumulator value, and stage 3 adds stage 2's new value. The output is c1 + (c2 - c2') + (c3 - 2c3' + c3''), where a prime marks the carry from one or two enabled samples earlier. A phase taken on enabled edge k reaches `div_off` on enabled edge k+2, and `chan_word` is taken on edge k+1.
- R7: `div_off` is a 5-bit two's-complement value that always lies in the range -3 to +4.
- R8: With the word held constant at W, the sum of `div_off` over any 2^FRAC_W consecutive enabled samples lies within 3 of W.
- R9: When `sample_en` is low, no state advances and `div_off` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Reference-rate advance strobe |
| phase_in | input | PHASE_W | Unsigned phase sample, modulo 2^PHASE_W |
| chan_word | input | FRAC_W | Fractional channel or raster offset |
| boost_en | input | 1 | Enables the high-boost term |
| boost_shift | input | SH_W | Boost gain as a power-of-two exponent |
| div_off | output | 5 | Signed divider offset around N |

## Verification
The assertions assume that reset is high from time zero and stays high across at least one edge, so the checker's own record of "first enabled sample seen" starts in a known state. The idle-hold property also assumes that reset is not raised in the cycle that follows an idle cycle. The bench raises reset only at the start and releases it on a falling edge. It changes `phase_in` during idle gaps to show that the frozen state ignores it, and it keeps random phase steps small, so that both the clamp and the unclamped region of the word are reached under the boost.

// File: rtl/phdiv_pkg.sv
package phdiv_pkg;

    localparam int DIV_W      = 5;
    localparam int MASH_ORDER = 3;
    localparam int DIV_LO     = -3;
    localparam int DIV_HI     = 4;

    typedef logic signed [DIV_W-1:0] div_off_t;

    // carries remembered from earlier enabled samples
    typedef struct packed {
        logic c2_d;
        logic c3_d;
        logic c3_dd;
    } carry_hist_t;

    // R6: cascade recombination of the three stage carries
    function automatic div_off_t mash_combine(input logic [MASH_ORDER-1:0] c,
                                              input carry_hist_t h);
        int v;
        v = int'(c[0])
          + int'(c[1]) - int'(h.c2_d)
          + int'(c[2]) - 2 * int'(h.c3_d) + int'(h.c3_dd);
        return div_off_t'(v);
    endfunction

endpackage

// File: rtl/phdiv_diff.sv
module phdiv_diff #(
    parameter int PHASE_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [PHASE_W-1:0]        phase_in,
    output logic signed [PHASE_W-1:0] freq_cur,
    output logic signed [PHASE_W-1:0] freq_old
);
    logic [PHASE_W-1:0] ph_prev;
    logic               primed;
    logic [PHASE_W-1:0] ph_delta;

    // modulo subtraction gives the wrap-free difference (R2)
    assign ph_delta = phase_in - ph_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_prev  <= '0;
            primed   <= 1'b0;
            freq_cur <= '0;
            freq_old <= '0;
        end else if (en) begin
            ph_prev  <= phase_in;
            primed   <= 1'b1;
            freq_old <= freq_cur;
            freq_cur <= primed ? $signed(ph_delta) : '0;   // R3
        end
    end
endmodule

// File: rtl/phdiv_emph.sv
module phdiv_emph #(
    parameter int PHASE_W = 16,
    parameter int FRAC_W  = 16,
    parameter int SH_W    = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic signed [PHASE_W-1:0] freq_cur,
    input  logic signed [PHASE_W-1:0] freq_old,
    input  logic                      boost_en,
    input  logic [SH_W-1:0]           boost_shift,
    input  logic [FRAC_W-1:0]         chan_word,
    output logic [FRAC_W-1:0]         word
);
    localparam int MAX_SH = (1 << SH_W) - 1;
    localparam int EW     = PHASE_W + 2 + MAX_SH;
    localparam int SW     = EW + FRAC_W + 2;

    logic signed [PHASE_W:0] slope;
    logic signed [EW-1:0]    boost_term;
    logic signed [EW-1:0]    emph;
    logic signed [SW-1:0]    total;
    logic [FRAC_W-1:0]       clamped;

    assign slope = (PHASE_W+1)'(freq_cur) - (PHASE_W+1)'(freq_old);

    // R4: high-boost term, gain selected as a power of two
    always_comb begin
        if (boost_en) boost_term = EW'(slope) <<< boost_shift;
        else          boost_term = '0;
    end

    assign emph  = EW'(freq_cur) + boost_term;
    // R5: doubled for the 2x oscillator, then channel added
    assign total = (SW'(emph) <<< 1) + $signed(SW'(chan_word));

    always_comb begin
        if (total[SW-1])                 clamped = '0;
        else if (|total[SW-2:FRAC_W])    clamped = '1;
        else                             clamped = total[FRAC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)     word <= '0;
        else if (en) word <= clamped;
    end
endmodule

// File: rtl/phdiv_mash.sv
module phdiv_mash
    import phdiv_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [FRAC_W-1:0] word,
    output div_off_t          div_off
);
    logic [FRAC_W-1:0]     acc_q  [MASH_ORDER];
    logic [FRAC_W-1:0]     acc_nx [MASH_ORDER];
    logic [MASH_ORDER-1:0] carry;
    carry_hist_t           hist_q;

    // each stage integrates the new residue of the stage before it
    always_comb begin
        logic [FRAC_W:0]   sum_t;
        logic [FRAC_W-1:0] stage_in;
        stage_in = word;
        for (int i = 0; i < MASH_ORDER; i++) begin
            sum_t     = {1'b0, acc_q[i]} + {1'b0, stage_in};
            acc_nx[i] = sum_t[FRAC_W-1:0];
            carry[i]  = sum_t[FRAC_W];
            stage_in  = sum_t[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MASH_ORDER; i++) acc_q[i] <= '0;
            hist_q  <= '0;
            div_off <= '0;
        end else if (en) begin
            for (int i = 0; i < MASH_ORDER; i++) acc_q[i] <= acc_nx[i];
            div_off <= mash_combine(carry, hist_q);
            hist_q  <= '{c2_d: carry[1], c3_d: carry[2], c3_dd: hist_q.c3_d};
        end
    end
endmodule

// File: rtl/phdiv_path.sv
module phdiv_path
    import phdiv_pkg::*;
#(
    parameter int PHASE_W = 16,
    parameter int FRAC_W  = 16,
    parameter int SH_W    = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_en,
    input  logic [PHASE_W-1:0]      phase_in,
    input  logic [FRAC_W-1:0]       chan_word,
    input  logic                    boost_en,
    input  logic [SH_W-1:0]         boost_shift,
    output logic signed [DIV_W-1:0] div_off
);
    logic signed [PHASE_W-1:0] freq_cur;
    logic signed [PHASE_W-1:0] freq_old;
    logic [FRAC_W-1:0]         word;

    phdiv_diff #(.PHASE_W(PHASE_W)) u_diff (
        .clk      (clk),
        .rst      (rst),
        .en       (sample_en),
        .phase_in (phase_in),
        .freq_cur (freq_cur),
        .freq_old (freq_old)
    );

    phdiv_emph #(.PHASE_W(PHASE_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_emph (
        .clk         (clk),
        .rst         (rst),
        .en          (sample_en),
        .freq_cur    (freq_cur),
        .freq_old    (freq_old),
        .boost_en    (boost_en),
        .boost_shift (boost_shift),
        .chan_word   (chan_word),
        .word        (word)
    );

    phdiv_mash #(.FRAC_W(FRAC_W)) u_mash (
        .clk     (clk),
        .rst     (rst),
        .en      (sample_en),
        .word    (word),
        .div_off (div_off)
    );
endmodule

// File: rtl/phdiv_path_chk.sv
module phdiv_path_chk #(
    parameter int PHASE_W = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      sample_en,
    input logic signed [4:0]         div_off,
    input logic signed [PHASE_W-1:0] freq_cur
);
    logic seen_en;

    always_ff @(posedge clk) begin
        if (rst)            seen_en <= 1'b0;
        else if (sample_en) seen_en <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (div_off == 5'sd0));

    assert_first_freq_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (sample_en && !seen_en) |=> (freq_cur == '0));

    assert_div_window_R7: assert property (@(posedge clk) disable iff (rst)
        (div_off >= -5'sd3) && (div_off <= 5'sd4));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(div_off));
endmodule

bind phdiv_path phdiv_path_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .div_off   (div_off),
    .freq_cur  (freq_cur)
);

// File: tb/phdiv_path_test.sv
module phdiv_path_test;
    localparam int PW  = 8;
    localparam int FW  = 8;
    localparam int SHW = 2;
    localparam int MOD = 1 << FW;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                 rst;
    logic                 sample_en;
    logic [PW-1:0]        phase_in;
    logic [FW-1:0]        chan_word;
    logic                 boost_en;
    logic [SHW-1:0]       boost_shift;
    logic signed [4:0]    div_off;

    phdiv_path #(.PHASE_W(PW), .FRAC_W(FW), .SH_W(SHW)) uut (
        .clk(clk), .rst(rst), .sample_en(sample_en), .phase_in(phase_in),
        .chan_word(chan_word), .boost_en(boost_en), .boost_shift(boost_shift),
        .div_off(div_off)
    );

    int    total = 0;
    int    bad   = 0;
    bit    finished = 0;
    string cur_req = "R6";
    int    cur_ph = 0;

    // reference state, written from the requirement equations
    int m_ph, m_primed, m_d, m_dp, m_w, m_a1, m_a2, m_a3;
    int m_c2d, m_c3d, m_c3dd, m_out;

    task automatic check_eq(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_near(string req, int act, int exp, int tol);
        total++;
        if (act > exp + tol || act < exp - tol) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (+/-%0d)", req, act, exp, tol);
        end
    endtask

    task automatic model_clear();
        m_ph = 0; m_primed = 0; m_d = 0; m_dp = 0; m_w = 0;
        m_a1 = 0; m_a2 = 0; m_a3 = 0;
        m_c2d = 0; m_c3d = 0; m_c3dd = 0; m_out = 0;
    endtask

    task automatic model_step(int ph);
        int f, e, w, t1, t2, t3, c1, c2, c3;
        if (m_primed != 0) begin
            f = (ph - m_ph) & (MOD - 1);          // R2
            if (f >= MOD / 2) f = f - MOD;
        end else f = 0;                           // R3
        e = m_d;
        if (boost_en) e = e + (m_d - m_dp) * (1 << int'(boost_shift));   // R4
        w = int'(chan_word) + 2 * e;              // R5
        if (w < 0) w = 0;
        if (w > MOD - 1) w = MOD - 1;
        t1 = m_a1 + m_w;  c1 = t1 / MOD; t1 = t1 % MOD;
        t2 = m_a2 + t1;   c2 = t2 / MOD; t2 = t2 % MOD;
        t3 = m_a3 + t2;   c3 = t3 / MOD; t3 = t3 % MOD;
        m_out  = c1 + (c2 - m_c2d) + (c3 - 2 * m_c3d + m_c3dd);
        m_c3dd = m_c3d; m_c3d = c3; m_c2d = c2;
        m_a1 = t1; m_a2 = t2; m_a3 = t3;
        m_w = w; m_dp = m_d; m_d = f; m_ph = ph; m_primed = 1;
    endtask

    // called at a falling edge; checks after the next rising edge
    task automatic tick(bit en, int ph);
        sample_en = en;
        phase_in  = ph[PW-1:0];
        if (en) model_step(ph);
        @(negedge clk);
        check_eq(cur_req, int'(div_off), m_out);
        total++;
        if (int'(div_off) < -3 || int'(div_off) > 4) begin
            bad++;
            $display("FAIL R7 actual=%0d expected=-3..4", int'(div_off));
        end
    endtask

    task automatic ramp(int step, int n);
        for (int i = 0; i < n; i++) begin
            cur_ph = (cur_ph + step) & (MOD - 1);
            tick(1'b1, cur_ph);
        end
    endtask

    // settle, then sum one full accumulator period
    task automatic window_sum(string req, int step, int expect_w, int tol);
        int acc;
        ramp(step, 5);
        acc = 0;
        for (int i = 0; i < MOD; i++) begin
            cur_ph = (cur_ph + step) & (MOD - 1);
            tick(1'b1, cur_ph);
            acc += int'(div_off);
        end
        check_near(req, acc, expect_w, tol);
    endtask

    initial begin
        rst = 1'b1; sample_en = 1'b0; phase_in = '0; chan_word = '0;
        boost_en = 1'b0; boost_shift = '0;
        model_clear();
        repeat (3) @(negedge clk);
        check_eq("R1", int'(div_off), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", int'(div_off), 0);

        // R3: a large first phase must not look like a frequency jump
        cur_req = "R3";
        for (int i = 0; i < 8; i++) begin
            tick(1'b1, 100);
            check_eq("R3", int'(div_off), 0);
        end
        cur_ph = 100;

        // R2: ramps that cross zero in both directions
        cur_req = "R2";
        chan_word = 8'd40;
        window_sum("R2", 20, 80, 3);
        chan_word = 8'd100;
        window_sum("R2", -10, 80, 3);

        // R5: clamp at both ends of the word range
        cur_req = "R5";
        chan_word = 8'd250;
        window_sum("R5", 30, 255, 3);
        chan_word = 8'd10;
        window_sum("R5", -20, 0, 3);

        // R9: idle cycles with moving phase leave everything frozen
        cur_req = "R9";
        chan_word = 8'd77;
        ramp(3, 20);
        begin
            int held;
            held = int'(div_off);
            for (int i = 0; i < 6; i++) begin
                tick(1'b0, (cur_ph + 37 * (i + 1)) & (MOD - 1));
                check_eq("R9", int'(div_off), held);
            end
        end
        ramp(3, 20);

        // R4: exact trace against the reference under every boost gain
        cur_req = "R4";
        chan_word = 8'd128;
        for (int sh = 0; sh < 4; sh++) begin
            boost_en = 1'b1;
            boost_shift = sh[SHW-1:0];
            for (int i = 0; i < 300; i++) begin
                cur_ph = (cur_ph + int'($urandom % 17) - 8) & (MOD - 1);
                tick(($urandom % 4) != 0, cur_ph);
            end
        end
        boost_en = 1'b0;

        // R8 with R6 tracking: every channel word, phase held still
        cur_req = "R6";
        for (int f = 0; f < MOD; f++) begin
            chan_word = f[FW-1:0];
            window_sum("R8", 0, f, 3);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule